// File: doc/BRIEF.md
# Dual-Phase Fixed-Frequency Current Chopper

This block is the digital timing core of a two-channel unipolar stepper driver that limits winding current by chopping. A single base counter runs at twice the chopping rate. Its ticks go to channel A and channel B in turn, so each channel starts a chopping cycle once per two ticks and the two channels start half a cycle apart. Their current peaks therefore never coincide.

Each channel has a parameterised number of phase pairs. Each pair has one high-side chopping switch, two low-side winding switches and one current comparator flag. At its channel's cycle start, a pair with at least one enabled winding turns its high-side switch on. A blanking counter then hides the comparator for a fixed number of clocks. After that, a comparator trip turns the high-side switch off for the rest of the cycle. While the high-side switch is off, the low-side switches of the enabled windings conduct so that the winding current can recirculate with less loss.

The oscillator period (`OSC_DIV`) and the blanking length (`LOCKOUT`) are given in system clock cycles. At 50 MHz, the defaults give a 20 kHz chopping rate and about 1.4 µs of blanking. Pair index `i = ch*NPAIR + p`, with channel A as ch 0 and channel B as ch 1. Pair `i` owns bit `i` of `trip_i` and of `hs_gate_o`, and bits `2i` and `2i+1` of `wind_en_i` and of `ls_gate_o`.

Top module: `chop_dual`

## Requirements
- R1: While `rst_n` is low, every bit of `hs_gate_o` and `ls_gate_o` is 0. After release, the base counter starts from zero and the first cycle start goes to channel A.
- R2: Counting clock edges after reset release, channel A starts a cycle at edge `OSC_DIV` and every `2*OSC_DIV` edges after that. Channel B starts at edge `2*OSC_DIV` and every `2*OSC_DIV` edges after that. No cycle starts earlier.
- R3: At a cycle start of its channel, each pair with at least one enabled winding drives its `hs_gate_o` bit high from the next clock edge.
- R4: For `LOCKOUT` cycles after the high-side switch turns on, the pair's `trip_i` bit is ignored.
- R5: A trip seen after the blanking window turns the pair's high-side switch off one edge later. It stays off until the next cycle start of that channel, even if `trip_i` falls again.
- R6: If `trip_i` is already high when the blanking window ends, the on-time is exactly `LOCKOUT+1` clock cycles.
- R7: Each `ls_gate_o` bit equals its `wind_en_i` bit while the pair's high-side switch is off, and is 0 while it is on. A disabled winding's low-side switch is always off.
- R8: Within one pair, the `hs_gate_o` bit and either of its `ls_gate_o` bits are never high in the same cycle.
- R9: A pair with no enabled winding turns its high-side switch off one edge after its enables drop. It is not turned on by a cycle start. Once re-enabled, it stays off until the next start of its channel.
- R10: A trip on one pair changes neither the other pairs nor the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 2*NPAIR | Per-pair comparator flag: sensed current reached the threshold |
| wind_en_i | input | 4*NPAIR | Per-winding enable, two bits per pair |
| hs_gate_o | output | 2*NPAIR | Per-pair high-side chopping switch enable |
| ls_gate_o | output | 4*NPAIR | Per-winding low-side switch enable |

## Verification
The assertions take `trip_i` and `wind_en_i` to be synchronous to `clk`, that is, already passed through synchronisers outside this block. They also take `OSC_DIV` to be at least 2 and larger than `LOCKOUT+1`, so that one channel's blanking window ends before that channel's next start. The stimulus changes every input only at falling clock edges. Comparator flags are raised either inside a blanking window or across a cycle start, and the enable pattern is varied only between known cycle starts. Every expected edge therefore falls at a cycle count that follows from `OSC_DIV` and `LOCKOUT` alone.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chop_ch_e;
endpackage

// File: rtl/chop_osc.sv
`timescale 1ns/1ps
module chop_osc
    import chop_pkg::*;
#(
    parameter int OSC_DIV = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_CH-1:0] sync_o
);
    localparam int CW = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSC_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        chop_ch_e      sel;
    } osc_st_t;

    osc_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d   = st_q;
        tick   = (st_q.cnt == LAST);
        sync_o = {tick && (st_q.sel == CH_B), tick && (st_q.sel == CH_A)};
        if (tick) begin
            st_d.cnt = '0;
            st_d.sel = (st_q.sel == CH_A) ? CH_B : CH_A;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A start is a single-cycle pulse and is never followed at once by the other channel
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o[0] |=> !sync_o[0] && !sync_o[1]);
    assert_start_single_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o[1] |=> !sync_o[1] && !sync_o[0]);
    assert_start_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sync_o));
endmodule

// File: rtl/chop_pair.sv
`timescale 1ns/1ps
module chop_pair #(
    parameter int LOCKOUT = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic       trip_i,
    input  logic [1:0] wind_en_i,
    output logic       hs_o,
    output logic [1:0] ls_o
);
    localparam int BW = $clog2(LOCKOUT + 2);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(LOCKOUT);

    typedef struct packed {
        logic          on;
        logic [BW-1:0] blank;
        logic [1:0]    ls;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     active;

    always_comb begin
        st_d       = st_q;
        active     = |wind_en_i;
        st_d.blank = (st_q.blank != '0) ? st_q.blank - 1'b1 : '0;
        if (sync_i) st_d.blank = BLANK_LOAD;

        if (!active)                             st_d.on = 1'b0;
        else if (sync_i)                         st_d.on = 1'b1;
        else if (st_q.blank == '0 && trip_i)     st_d.on = 1'b0;

        st_d.ls = wind_en_i & {2{~st_d.on}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o = st_q.on;
    assign ls_o = st_q.ls;

    assert_no_shoot_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && (ls_o != 2'b00)));
    assert_start_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && (wind_en_i != 2'b00)) |=> hs_o);
    assert_blank_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank != '0 && hs_o && (wind_en_i != 2'b00)) |=> hs_o);
    assert_trip_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank == '0 && trip_i && !sync_i && hs_o) |=> !hs_o);
    assert_off_until_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_o && !sync_i) |=> !hs_o);
    assert_idle_pair_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wind_en_i == 2'b00) |=> !hs_o && (ls_o == 2'b00));
endmodule

// File: rtl/chop_dual.sv
`timescale 1ns/1ps
module chop_dual
    import chop_pkg::*;
#(
    parameter int NPAIR   = 2,
    parameter int OSC_DIV = 1250,
    parameter int LOCKOUT = 70
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*NPAIR-1:0]   trip_i,
    input  logic [2*NUM_CH*NPAIR-1:0] wind_en_i,
    output logic [NUM_CH*NPAIR-1:0]   hs_gate_o,
    output logic [2*NUM_CH*NPAIR-1:0] ls_gate_o
);
    logic [NUM_CH-1:0] sync;

    chop_osc #(.OSC_DIV(OSC_DIV)) u_osc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_o (sync)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            localparam int IDX = c*NPAIR + p;
            chop_pair #(.LOCKOUT(LOCKOUT)) u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync_i    (sync[c]),
                .trip_i    (trip_i[IDX]),
                .wind_en_i (wind_en_i[2*IDX +: 2]),
                .hs_o      (hs_gate_o[IDX]),
                .ls_o      (ls_gate_o[2*IDX +: 2])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (hs_gate_o == '0 && ls_gate_o == '0)
                else $error("gate enable active during reset");
        end
    end
endmodule

// File: tb/chop_dual_bench.sv
`timescale 1ns/1ps
module chop_dual_bench;
    localparam int DIV = 20;
    localparam int LCK = 4;
    localparam int NPR = 2;
    localparam int NPT = 2*NPR;
    localparam int NW  = 2*NPT;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPT-1:0] trip = '0;
    logic [NW-1:0]  wen = '0;
    logic [NPT-1:0] hs;
    logic [NW-1:0]  ls;

    chop_dual #(.NPAIR(NPR), .OSC_DIV(DIV), .LOCKOUT(LCK)) u_chop_dual (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_i    (trip),
        .wind_en_i (wen),
        .hs_gate_o (hs),
        .ls_gate_o (ls)
    );

    always #10 clk = ~clk;

    int cyc;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    typedef struct {
        int             at;
        logic [NPT-1:0] hs;
        logic [NW-1:0]  ls;
        string          tag;
    } exp_t;
    exp_t sb[$];

    int total = 0;
    int bad   = 0;

    task automatic expect_at(input int at, input logic [NPT-1:0] h,
                             input logic [NW-1:0] l, input string tag);
        exp_t e;
        e.at = at; e.hs = h; e.ls = l; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard when its cycle comes up
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            for (int i = 0; i < NPT; i++) begin
                total++;
                if (hs[i] && ls[2*i +: 2] != 2'b00) begin
                    bad++;
                    $display("FAIL R8 cyc=%0d pair=%0d hs=%b ls=%b expected no overlap",
                             cyc, i, hs[i], ls[2*i +: 2]);
                end
            end
            if (sb.size() > 0 && sb[0].at <= cyc) begin
                e = sb.pop_front();
                total++;
                if (e.at != cyc) begin
                    bad++;
                    $display("FAIL %s missed cyc=%0d expected at %0d", e.tag, cyc, e.at);
                end else if (hs !== e.hs || ls !== e.ls) begin
                    bad++;
                    $display("FAIL %s cyc=%0d hs=%b ls=%h expected hs=%b ls=%h",
                             e.tag, cyc, hs, ls, e.hs, e.ls);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        do @(negedge clk); while (cyc != n);
    endtask

    task automatic check_reset_quiet(input string tag);
        total++;
        if (hs !== '0 || ls !== '0) begin
            bad++;
            $display("FAIL %s hs=%b ls=%h expected hs=0000 ls=00", tag, hs, ls);
        end
    endtask

    task automatic run_all();
        wen   = 8'h69;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_quiet("R1 reset");
        rst_n = 1'b1;

        expect_at(1,   4'b0000, 8'h69, "R1 R7 idle after release");
        expect_at(19,  4'b0000, 8'h69, "R2 no early start");
        expect_at(20,  4'b0011, 8'h60, "R3 R7 channel A start");
        expect_at(39,  4'b0011, 8'h60, "R2 channel B waits");
        expect_at(40,  4'b1111, 8'h00, "R2 channel B half period later");
        expect_at(64,  4'b1111, 8'h00, "R4 trip ignored in blanking");
        expect_at(65,  4'b1110, 8'h01, "R5 R10 trip pair0 only");
        expect_at(80,  4'b1110, 8'h01, "R5 R10 B start leaves A off");
        expect_at(99,  4'b1110, 8'h01, "R5 held off to next start");
        expect_at(100, 4'b1111, 8'h00, "R3 pair0 restarts");
        wait_cyc(61);  trip[0] = 1'b1;
        wait_cyc(66);  trip[0] = 1'b0;

        expect_at(104, 4'b1111, 8'h00, "R4 pair1 blanking");
        expect_at(105, 4'b1101, 8'h08, "R5 pair1 trip");
        expect_at(139, 4'b1101, 8'h08, "R5 pair1 still off");
        expect_at(140, 4'b1111, 8'h00, "R6 start with trip high");
        expect_at(144, 4'b1111, 8'h00, "R6 held through blanking");
        expect_at(145, 4'b1101, 8'h08, "R6 off after LOCKOUT+1");
        wait_cyc(101); trip[1] = 1'b1;
        wait_cyc(146); trip[1] = 1'b0;

        expect_at(151, 4'b1001, 8'h08, "R9 disabled pair drops");
        expect_at(160, 4'b1001, 8'h08, "R9 start ignored when idle");
        expect_at(180, 4'b1011, 8'h00, "R3 pair1 back on");
        wait_cyc(150); wen = 8'h49;

        expect_at(183, 4'b1011, 8'h10, "R9 R7 re-enabled waits");
        expect_at(199, 4'b1011, 8'h10, "R9 still waiting");
        expect_at(200, 4'b1111, 8'h00, "R3 B restart");
        wait_cyc(182); wen = 8'h59;

        wait_cyc(205);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 pending=%0d expected 0", sb.size());
        end

        rst_n = 1'b0;
        @(negedge clk);
        check_reset_quiet("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        expect_at(1,  4'b0000, 8'h59, "R1 restart idle");
        expect_at(19, 4'b0000, 8'h59, "R1 counter restarted");
        expect_at(20, 4'b0011, 8'h50, "R1 first start to A");
        expect_at(40, 4'b1111, 8'h00, "R2 then B");
        wait_cyc(41);
    endtask

    initial begin
        fork
            run_all();
            begin
                #1_000_000;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule